// File: doc/BRIEF.md
# Load/Store Address Generation and Data Memory

This block serves the load and store instructions of a 32-bit big-endian core. A request gives the access kind, whether the offset is an immediate or a second register, whether the base register is updated, the access size, the base and index register values and numbers, a 16-bit displacement and the store data. From these the block forms the effective address. It checks the alignment and the validity of the update. It reads or writes a byte-addressed memory built from two RAM segments and a computed ROM at the top of a 16-bit space. It reports the result one clock later.

Update forms return the effective address on `wb_ea` with `wb_en` set, so the register file can write it back into the base register. Only the low 16 bits of the effective address select a location. A peripheral bank is decoded and reported, but the peripherals themselves sit outside this block. Loads from the bank read zero and stores to it have no effect here.

Top module: `ldst_unit`

## Requirements
- R1: With `req_indexed`=0 the effective address is the base plus the 16-bit displacement sign-extended to 32 bits. It is reported on `wb_ea` in every response.
- R2: With `req_indexed`=1 the effective address is the base plus `rb_val`, modulo 2^32.
- R3: In a non-update request (`req_update`=0) whose `ra_idx` is 0, the base is zero and `ra_val` is not used. Otherwise the base is `ra_val`.
- R4: An update request that is neither invalid nor misaligned raises `wb_en`, with `wb_ea` equal to the effective address.
- R5: An update request is invalid when `ra_idx` is 0, or when it is a load and `ra_idx` equals `rd_idx`. An invalid update sets `err_badupd` and keeps `wb_en` low, but the access itself still takes place.
- R6: Size codes are 0 for a byte, 1 for a halfword and 2 for a word; code 3 acts as a word. Memory is big endian: the byte at the lowest address is the most significant byte of a halfword or word. Load data is zero-extended to 32 bits.
- R7: A halfword at an odd address, or a word at an address whose two low bits are not 00, sets `err_misalign`. Such a request reads nothing, writes nothing, raises no `wb_en`, and returns `ld_data`=0.
- R8: `rsp_region` codes are: 0 unmapped, 1 RAM segment 0 at 0x0000, 2 RAM segment 1 at 0x1000, 3 peripheral bank at 0x8000 (2^PERIPH_BITS bytes), and 4 ROM occupying the top 2^SEG_BITS bytes. Each RAM segment is 2^SEG_BITS bytes. Loads from regions 0 and 3 return 0, and stores to them change nothing.
- R9: The ROM byte at address A reads as A[7:0] XOR 0x5A. A store to the ROM changes nothing and sets `err_wprot`.
- R10: A response (`rsp_valid`, `ld_data`, `wb_en`, `wb_ea`, `rsp_region`, error flags) appears exactly one clock after `req_valid`. With no response, all of these are 0 except `wb_ea`. Bits 31..16 of the effective address do not affect which location is accessed.
- R11: Each RAM segment keeps what is stored into it. A load returns the most recent stored bytes, and the two segments do not alias each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_indexed | input | 1 | 1 = base + rb_val, 0 = base + displacement |
| req_update | input | 1 | Write effective address back to the base register |
| req_size | input | 2 | Access size code |
| ra_idx | input | 5 | Base register number |
| rd_idx | input | 5 | Load destination register number |
| ra_val | input | 32 | Base register value |
| rb_val | input | 32 | Index register value |
| disp | input | 16 | Displacement |
| st_data | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Response present |
| ld_data | output | 32 | Zero-extended load data |
| wb_en | output | 1 | Base register write-back enable |
| wb_ea | output | 32 | Effective address |
| rsp_region | output | 3 | Region code of the access |
| err_misalign | output | 1 | Misaligned access |
| err_wprot | output | 1 | Store to ROM |
| err_badupd | output | 1 | Invalid update form |

## Verification
The bench builds the block with SEG_BITS=6 and PERIPH_BITS=4, which gives 64-byte RAM segments, a 64-byte ROM at 0xFFC0 and a 16-byte peripheral bank. With segments this small, every byte offset of both RAM segments and of the ROM can be loaded with every size code, so every big-endian lane position and every misalignment case is covered. The bench then runs partial-width overwrites, writes to the protected and unmapped regions, upper-address aliasing, negative offsets and each update-validity rule. It checks all of these against a byte-level model.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WRSV = 2'd3
   } size_e;

   typedef enum logic [2:0] {
      RG_NONE   = 3'd0,
      RG_RAM0   = 3'd1,
      RG_RAM1   = 3'd2,
      RG_PERIPH = 3'd3,
      RG_ROM    = 3'd4
   } region_e;

   // Computed ROM contents (R9): byte value from the low address byte
   function automatic logic [7:0] rom_byte(input logic [7:0] lo);
      return lo ^ 8'h5A;
   endfunction

endpackage

// File: rtl/ldst_agen.sv
module ldst_agen #(
   parameter int DATA_W = 32,
   parameter int DISP_W = 16,
   parameter int RIDX_W = 5
) (
   input  logic              indexed,
   input  logic              update,
   input  logic              store,
   input  logic [RIDX_W-1:0] ra_idx,
   input  logic [RIDX_W-1:0] rd_idx,
   input  logic [DATA_W-1:0] ra_val,
   input  logic [DATA_W-1:0] rb_val,
   input  logic [DISP_W-1:0] disp,
   output logic [DATA_W-1:0] ea,
   output logic              bad_upd
);
   localparam int EXT_W = DATA_W - DISP_W;

   if (DISP_W > DATA_W) begin : g_chk_disp
      $error("ldst_agen: displacement wider than data path");
   end

   logic              ra_zero;
   logic [DATA_W-1:0] base;
   logic [DATA_W-1:0] offset;

   assign ra_zero = (ra_idx == '0);

   always_comb begin
      // R3: register number zero means a zero base outside update forms
      base   = (!update && ra_zero) ? '0 : ra_val;
      // R1 / R2
      offset = indexed ? rb_val : {{EXT_W{disp[DISP_W-1]}}, disp};
      ea     = base + offset;
   end

   // R5
   assign bad_upd = update && (ra_zero || (!store && (ra_idx == rd_idx)));

endmodule

// File: rtl/ldst_region_dec.sv
module ldst_region_dec
   import ldst_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter int          SEG_BITS    = 12,
   parameter int          PERIPH_BITS = 8,
   parameter int unsigned RAM0_BASE   = 32'h0000,
   parameter int unsigned RAM1_BASE   = 32'h1000,
   parameter int unsigned PERIPH_BASE = 32'h8000
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);
   localparam logic [ADDR_W-1:0] R0_B  = ADDR_W'(RAM0_BASE);
   localparam logic [ADDR_W-1:0] R1_B  = ADDR_W'(RAM1_BASE);
   localparam logic [ADDR_W-1:0] PB_B  = ADDR_W'(PERIPH_BASE);
   localparam logic [ADDR_W-1:0] ROM_B = {ADDR_W{1'b1}} << SEG_BITS;
   localparam int unsigned SEG_MASK = (32'd1 << SEG_BITS) - 1;
   localparam int unsigned PB_MASK  = (32'd1 << PERIPH_BITS) - 1;

   if (SEG_BITS < 3 || SEG_BITS > ADDR_W - 2) begin : g_chk_seg
      $error("ldst_region_dec: SEG_BITS out of range");
   end
   if (PERIPH_BITS < 2 || PERIPH_BITS > ADDR_W - 1) begin : g_chk_pb
      $error("ldst_region_dec: PERIPH_BITS out of range");
   end
   if (((RAM0_BASE | RAM1_BASE) & SEG_MASK) != 0) begin : g_chk_ralign
      $error("ldst_region_dec: RAM base not aligned to segment size");
   end
   if ((PERIPH_BASE & PB_MASK) != 0) begin : g_chk_palign
      $error("ldst_region_dec: peripheral base not aligned");
   end

   logic hit_r0, hit_r1, hit_pb, hit_rom;

   assign hit_rom = (addr[ADDR_W-1:SEG_BITS]    == ROM_B[ADDR_W-1:SEG_BITS]);
   assign hit_r0  = (addr[ADDR_W-1:SEG_BITS]    == R0_B[ADDR_W-1:SEG_BITS]);
   assign hit_r1  = (addr[ADDR_W-1:SEG_BITS]    == R1_B[ADDR_W-1:SEG_BITS]);
   assign hit_pb  = (addr[ADDR_W-1:PERIPH_BITS] == PB_B[ADDR_W-1:PERIPH_BITS]);

   // R8: fixed priority in case a configuration makes regions overlap
   always_comb begin
      if (hit_rom)     region = RG_ROM;
      else if (hit_r0) region = RG_RAM0;
      else if (hit_r1) region = RG_RAM1;
      else if (hit_pb) region = RG_PERIPH;
      else             region = RG_NONE;
   end

endmodule

// File: rtl/ldst_ram_bank.sv
module ldst_ram_bank #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 10,
   localparam int NBYTE = DATA_W / 8,
   localparam int WORDS = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [NBYTE-1:0]  be,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [WORDS];

   // R11: byte-enabled storage, registered read
   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int b = 0; b < NBYTE; b++) begin
            if (be[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
         end
      end
      if (rd_en) rdata <= mem[idx];
   end

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
   import ldst_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          ADDR_W      = 16,
   parameter int          DISP_W      = 16,
   parameter int          RIDX_W      = 5,
   parameter int          SEG_BITS    = 12,
   parameter int          PERIPH_BITS = 8,
   parameter int unsigned RAM0_BASE   = 32'h0000,
   parameter int unsigned RAM1_BASE   = 32'h1000,
   parameter int unsigned PERIPH_BASE = 32'h8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic              req_indexed,
   input  logic              req_update,
   input  logic [1:0]        req_size,
   input  logic [RIDX_W-1:0] ra_idx,
   input  logic [RIDX_W-1:0] rd_idx,
   input  logic [DATA_W-1:0] ra_val,
   input  logic [DATA_W-1:0] rb_val,
   input  logic [DISP_W-1:0] disp,
   input  logic [DATA_W-1:0] st_data,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] ld_data,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_ea,
   output logic [2:0]        rsp_region,
   output logic              err_misalign,
   output logic              err_wprot,
   output logic              err_badupd
);
   localparam int NBYTE  = DATA_W / 8;
   localparam int IDX_W  = SEG_BITS - 2;
   localparam int NBANKS = 2;

   if (DATA_W != 32) begin : g_chk_dw
      $error("ldst_unit: lane logic is built for a 32-bit word");
   end
   if (ADDR_W > DATA_W || ADDR_W < 8) begin : g_chk_aw
      $error("ldst_unit: ADDR_W out of range");
   end

   // ---------------- request stage ----------------
   logic [DATA_W-1:0] ea;
   logic              bad_upd;
   logic [ADDR_W-1:0] a16;
   region_e           region;
   size_e             size;
   logic              misalign;
   logic              go;
   logic [NBYTE-1:0]  be;
   logic [DATA_W-1:0] wlane;

   ldst_agen #(
      .DATA_W (DATA_W),
      .DISP_W (DISP_W),
      .RIDX_W (RIDX_W)
   ) u_agen (
      .indexed (req_indexed),
      .update  (req_update),
      .store   (req_store),
      .ra_idx  (ra_idx),
      .rd_idx  (rd_idx),
      .ra_val  (ra_val),
      .rb_val  (rb_val),
      .disp    (disp),
      .ea      (ea),
      .bad_upd (bad_upd)
   );

   // R10: only the low ADDR_W bits select a location
   assign a16 = ea[ADDR_W-1:0];

   ldst_region_dec #(
      .ADDR_W      (ADDR_W),
      .SEG_BITS    (SEG_BITS),
      .PERIPH_BITS (PERIPH_BITS),
      .RAM0_BASE   (RAM0_BASE),
      .RAM1_BASE   (RAM1_BASE),
      .PERIPH_BASE (PERIPH_BASE)
   ) u_dec (
      .addr   (a16),
      .region (region)
   );

   assign size = size_e'(req_size);

   // R7: alignment check; R6: size code 3 acts as a word
   always_comb begin
      unique case (size)
         SZ_BYTE: misalign = 1'b0;
         SZ_HALF: misalign = a16[0];
         default: misalign = (a16[1:0] != 2'b00);
      endcase
   end

   assign go = req_valid && !misalign;

   // R6: big-endian lanes, lane bit 3 carries data bits 31..24 (lowest address)
   always_comb begin
      unique case (size)
         SZ_BYTE: begin
            be    = 4'b1000 >> a16[1:0];
            wlane = {NBYTE{st_data[7:0]}};
         end
         SZ_HALF: begin
            be    = a16[1] ? 4'b0011 : 4'b1100;
            wlane = {2{st_data[15:0]}};
         end
         default: begin
            be    = 4'b1111;
            wlane = st_data;
         end
      endcase
   end

   // ---------------- storage ----------------
   logic [NBANKS-1:0][DATA_W-1:0] bank_rd;
   logic [DATA_W-1:0]             rom_q;

   for (genvar i = 0; i < NBANKS; i++) begin : g_bank
      localparam region_e MY_RG = (i == 0) ? RG_RAM0 : RG_RAM1;
      logic sel;
      assign sel = go && (region == MY_RG);

      ldst_ram_bank #(
         .DATA_W (DATA_W),
         .IDX_W  (IDX_W)
      ) u_bank (
         .clk   (clk),
         .wr_en (sel && req_store),
         .rd_en (sel && !req_store),
         .be    (be),
         .idx   (a16[SEG_BITS-1:2]),
         .wdata (wlane),
         .rdata (bank_rd[i])
      );
   end

   // R9: ROM word computed from the address, never written
   always_ff @(posedge clk) begin
      if (go && !req_store && region == RG_ROM) begin
         for (int b = 0; b < NBYTE; b++) begin
            rom_q[DATA_W-8-8*b +: 8] <= rom_byte({a16[7:2], 2'(b)});
         end
      end
   end

   // ---------------- response stage (R10) ----------------
   logic              q_load_ok;
   region_e           q_region;
   size_e             q_size;
   logic [1:0]        q_lane;
   logic [DATA_W-1:0] q_ea;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         wb_en        <= 1'b0;
         err_misalign <= 1'b0;
         err_wprot    <= 1'b0;
         err_badupd   <= 1'b0;
         q_load_ok    <= 1'b0;
         q_region     <= RG_NONE;
         q_size       <= SZ_BYTE;
         q_lane       <= 2'b00;
         q_ea         <= '0;
      end else begin
         rsp_valid    <= req_valid;
         // R4 / R5 / R7
         wb_en        <= req_valid && req_update && !bad_upd && !misalign;
         err_misalign <= req_valid && misalign;
         err_wprot    <= go && req_store && (region == RG_ROM);
         err_badupd   <= req_valid && bad_upd;
         q_load_ok    <= go && !req_store;
         q_region     <= req_valid ? region : RG_NONE;
         q_size       <= size;
         q_lane       <= a16[1:0];
         if (req_valid) q_ea <= ea;
      end
   end

   assign wb_ea      = q_ea;
   assign rsp_region = q_region;

   // R6 / R8: select source word, extract lane, zero-extend
   logic [DATA_W-1:0] src_w;

   always_comb begin
      unique case (q_region)
         RG_RAM0: src_w = bank_rd[0];
         RG_RAM1: src_w = bank_rd[1];
         RG_ROM:  src_w = rom_q;
         default: src_w = '0;
      endcase
      ld_data = '0;
      if (q_load_ok) begin
         unique case (q_size)
            SZ_BYTE: ld_data[7:0]  = src_w[DATA_W-8-8*q_lane +: 8];
            SZ_HALF: ld_data[15:0] = q_lane[1] ? src_w[15:0] : src_w[31:16];
            default: ld_data       = src_w;
         endcase
      end
   end

endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_indexed,
   input logic        req_update,
   input logic [1:0]  req_size,
   input logic [4:0]  ra_idx,
   input logic [31:0] ra_val,
   input logic [15:0] disp,
   input logic        rsp_valid,
   input logic [31:0] ld_data,
   input logic        wb_en,
   input logic [31:0] wb_ea,
   input logic [2:0]  rsp_region,
   input logic        err_misalign,
   input logic        err_wprot,
   input logic        err_badupd
);

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R10

   AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!wb_en && ld_data == 32'd0 && rsp_region == 3'd0 &&
                      !err_misalign && !err_wprot && !err_badupd)); // R10

   AST_EA_DISP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_indexed && (req_update || ra_idx != 5'd0)) |=>
      (wb_ea == $past(ra_val) + {{16{$past(disp[15])}}, $past(disp)})); // R1

   AST_ZERO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_indexed && !req_update && ra_idx == 5'd0) |=>
      (wb_ea == {{16{$past(disp[15])}}, $past(disp)})); // R3

   AST_MISALIGN_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      err_misalign |-> (!wb_en && ld_data == 32'd0)); // R7

   AST_BADUPD_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      err_badupd |-> !wb_en); // R5

   AST_WB_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_update) |=> !wb_en); // R4

   AST_WPROT_IN_ROM: assert property (@(posedge clk) disable iff (!rst_n)
      err_wprot |-> (rsp_region == 3'd4)); // R9

   AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd0) |=> (ld_data[31:8] == 24'd0)); // R6

   AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd1) |=> (ld_data[31:16] == 16'd0)); // R6

endmodule

bind ldst_unit ldst_unit_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_indexed  (req_indexed),
   .req_update   (req_update),
   .req_size     (req_size),
   .ra_idx       (ra_idx),
   .ra_val       (ra_val),
   .disp         (disp),
   .rsp_valid    (rsp_valid),
   .ld_data      (ld_data),
   .wb_en        (wb_en),
   .wb_ea        (wb_ea),
   .rsp_region   (rsp_region),
   .err_misalign (err_misalign),
   .err_wprot    (err_wprot),
   .err_badupd   (err_badupd)
);

// File: tb/ldst_unit_tb.sv
module ldst_unit_tb;
   localparam int SEG  = 64;
   localparam int ROMB = 32'h10000 - SEG;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_store = 1'b0, req_indexed = 1'b0, req_update = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [4:0]  ra_idx = 5'd0, rd_idx = 5'd0;
   logic [31:0] ra_val = '0, rb_val = '0, st_data = '0;
   logic [15:0] disp = '0;
   logic        rsp_valid, wb_en, err_misalign, err_wprot, err_badupd;
   logic [31:0] ld_data, wb_ea;
   logic [2:0]  rsp_region;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] mdl [0:2*SEG-1];

   always #10 clk = ~clk;

   ldst_unit #(.SEG_BITS(6), .PERIPH_BITS(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_indexed(req_indexed), .req_update(req_update), .req_size(req_size),
      .ra_idx(ra_idx), .rd_idx(rd_idx), .ra_val(ra_val), .rb_val(rb_val),
      .disp(disp), .st_data(st_data), .rsp_valid(rsp_valid), .ld_data(ld_data),
      .wb_en(wb_en), .wb_ea(wb_ea), .rsp_region(rsp_region),
      .err_misalign(err_misalign), .err_wprot(err_wprot), .err_badupd(err_badupd));

   function automatic int rgn(input logic [15:0] a);
      if (a >= 16'(ROMB))                 return 4;
      if (a < 16'(SEG))                   return 1;
      if (a >= 16'h1000 && a < 16'h1040)  return 2;
      if (a >= 16'h8000 && a < 16'h8010)  return 3;
      return 0;
   endfunction

   function automatic logic [7:0] rd_byte(input logic [15:0] a);
      case (rgn(a))
         1: return mdl[a[5:0]];
         2: return mdl[SEG + int'(a[5:0])];
         4: return a[7:0] ^ 8'h5A;
         default: return 8'h00;
      endcase
   endfunction

   task automatic run(input bit st, input bit ix, input bit up, input logic [1:0] sz,
                      input logic [4:0] rai, input logic [4:0] rdi,
                      input logic [31:0] rav, input logic [31:0] rbv,
                      input logic [15:0] dsp, input logic [31:0] sd, input string tag);
      logic [31:0] base, ea, exp_ld;
      logic [15:0] a;
      int rg, nb;
      bit mis, bad, wb, wp;
      base = (!up && rai == 5'd0) ? 32'd0 : rav;
      ea   = base + (ix ? rbv : {{16{dsp[15]}}, dsp});
      a    = ea[15:0];
      rg   = rgn(a);
      nb   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      mis  = (sz == 2'd1 && a[0]) || (sz[1] && a[1:0] != 2'b00);
      bad  = up && (rai == 5'd0 || (!st && rai == rdi));
      wb   = up && !bad && !mis;
      wp   = st && !mis && rg == 4;
      exp_ld = '0;
      if (!st && !mis)
         for (int k = 0; k < nb; k++) exp_ld = {exp_ld[23:0], rd_byte(a + 16'(k))};
      if (st && !mis && (rg == 1 || rg == 2))
         for (int k = 0; k < nb; k++)
            mdl[(rg == 2 ? SEG : 0) + int'(a[5:0]) + k] = sd[8*(nb-1-k) +: 8];
      req_valid = 1'b1; req_store = st; req_indexed = ix; req_update = up;
      req_size = sz; ra_idx = rai; rd_idx = rdi; ra_val = rav; rb_val = rbv;
      disp = dsp; st_data = sd;
      @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (rsp_valid !== 1'b1 || ld_data !== exp_ld || wb_en !== wb || wb_ea !== ea ||
          rsp_region !== 3'(rg) || err_misalign !== mis || err_wprot !== wp ||
          err_badupd !== bad) begin
         n_fail++;
         $display("FAIL %s: a=%h ld=%h exp %h wb=%b exp %b ea=%h exp %h rg=%0d exp %0d mis/wp/bad=%b%b%b exp %b%b%b v=%b",
                  tag, a, ld_data, exp_ld, wb_en, wb, wb_ea, ea, rsp_region, rg,
                  err_misalign, err_wprot, err_badupd, mis, wp, bad, rsp_valid);
      end
      req_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      n_chk++;   // R10: reset state
      if (rsp_valid !== 1'b0 || wb_en !== 1'b0 || ld_data !== 32'd0 || rsp_region !== 3'd0 ||
          err_misalign !== 1'b0 || err_wprot !== 1'b0 || err_badupd !== 1'b0) begin
         n_fail++;
         $display("FAIL R10 reset: v=%b wb=%b ld=%h rg=%0d expected all zero",
                  rsp_valid, wb_en, ld_data, rsp_region);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R11: fill both segments with word stores (displacement form)
      for (int s = 0; s < 2; s++)
         for (int w = 0; w < SEG/4; w++)
            run(1, 0, 0, 2'd2, 5'd2, 5'd9, s ? 32'h1000 : 32'h0, 32'h0, 16'(4*w),
                32'hC0DE0000 ^ (32'(s) << 12) ^ (32'(w) * 32'h01030507), "R11");

      // R6 / R7: every offset and size code in both segments (indexed form, R2)
      for (int s = 0; s < 2; s++)
         for (int o = 0; o < SEG; o++)
            for (int z = 0; z < 4; z++)
               run(0, 1, 0, 2'(z), 5'd4, 5'd7, s ? 32'h1000 : 32'h0, 32'(o), 16'h0, 32'h0,
                   ((z == 1 && o % 2 != 0) || (z >= 2 && o % 4 != 0)) ? "R7" : "R6");

      // R6: byte stores, then R4: halfword stores with update
      for (int o = 0; o < SEG; o += 5)
         run(1, 0, 0, 2'd0, 5'd3, 5'd0, 32'h0, 32'h0, 16'(o), 32'hFFFFFF00 | 32'(o), "R6");
      for (int o = 0; o < SEG; o += 6)
         run(1, 0, 1, 2'd1, 5'd5, 5'd5, 32'h1000, 32'h0, 16'(o), 32'hABCD0000 | 32'(o * 3), "R4");
      for (int s = 0; s < 2; s++)
         for (int w = 0; w < SEG/4; w++)
            run(0, 0, 0, 2'd2, 5'd6, 5'd1, s ? 32'h1000 : 32'h0, 32'h0, 16'(4*w), 32'h0, "R11");

      // R9 / R3: ROM sweep through zero base with negative displacement
      for (int o = 0; o < SEG; o++)
         for (int z = 0; z < 3; z++)
            run(0, 0, 0, 2'(z), 5'd0, 5'd1, 32'hDEAD0000, 32'h0, 16'(ROMB + o), 32'h0, "R9");
      run(1, 0, 0, 2'd2, 5'd0, 5'd0, 32'h0, 32'h0, 16'(ROMB + 8), 32'h11223344, "R9");
      run(1, 0, 0, 2'd0, 5'd0, 5'd0, 32'h0, 32'h0, 16'(ROMB + 9), 32'h77, "R9");
      run(0, 0, 0, 2'd2, 5'd0, 5'd1, 32'h0, 32'h0, 16'(ROMB + 8), 32'h0, "R9");

      // R8: peripheral bank and unmapped space
      for (int o = 0; o < 16; o += 4) begin
         run(1, 0, 0, 2'd2, 5'd0, 5'd0, 32'h0, 32'h0, 16'(32'h8000 + o), 32'hCAFEF00D, "R8");
         run(0, 0, 0, 2'd2, 5'd0, 5'd1, 32'h0, 32'h0, 16'(32'h8000 + o), 32'h0, "R8");
      end
      run(1, 0, 0, 2'd2, 5'd0, 5'd0, 32'h0, 32'h0, 16'h0040, 32'h5555AAAA, "R8");
      run(0, 0, 0, 2'd2, 5'd0, 5'd1, 32'h0, 32'h0, 16'h0040, 32'h0, "R8");
      run(0, 0, 0, 2'd2, 5'd0, 5'd1, 32'h0, 32'h0, 16'h4000, 32'h0, "R8");
      run(0, 0, 0, 2'd2, 5'd0, 5'd1, 32'h0, 32'h0, 16'h1040, 32'h0, "R8");
      run(0, 0, 0, 2'd2, 5'd0, 5'd1, 32'h0, 32'h0, 16'h0000, 32'h0, "R11");

      // R1: negative displacement; R2: negative index
      run(0, 0, 0, 2'd2, 5'd8, 5'd1, 32'h1010, 32'h0, 16'hFFF0, 32'h0, "R1");
      run(0, 1, 0, 2'd1, 5'd8, 5'd1, 32'h1020, 32'hFFFFFFF0, 16'h0, 32'h0, "R2");
      // R10: upper address bits ignored
      run(0, 0, 0, 2'd2, 5'd8, 5'd1, 32'hABCD0000, 32'h0, 16'h0004, 32'h0, "R10");
      run(1, 1, 0, 2'd2, 5'd8, 5'd1, 32'h7FFF1000, 32'h8, 16'h0, 32'h0BADBEEF, "R10");
      run(0, 0, 0, 2'd2, 5'd8, 5'd1, 32'h1000, 32'h0, 16'h0008, 32'h0, "R10");
      // R3: zero base in indexed form
      run(0, 1, 0, 2'd2, 5'd0, 5'd1, 32'h00005555, 32'h1004, 16'h0, 32'h0, "R3");

      // R4 / R5: update-form rules
      run(0, 0, 1, 2'd2, 5'd6, 5'd7, 32'h1000, 32'h0, 16'h000C, 32'h0, "R4");
      run(0, 1, 1, 2'd0, 5'd6, 5'd7, 32'h0010, 32'h3, 16'h0, 32'h0, "R4");
      run(0, 0, 1, 2'd2, 5'd0, 5'd7, 32'h1000, 32'h0, 16'h0004, 32'h0, "R5");
      run(0, 0, 1, 2'd2, 5'd7, 5'd7, 32'h1000, 32'h0, 16'h0004, 32'h0, "R5");
      run(1, 0, 1, 2'd2, 5'd0, 5'd0, 32'h1000, 32'h0, 16'h0004, 32'h13579BDF, "R5");
      run(0, 0, 1, 2'd2, 5'd0, 5'd0, 32'h1000, 32'h0, 16'h0004, 32'h0, "R5");
      run(1, 0, 1, 2'd2, 5'd7, 5'd7, 32'h0000, 32'h0, 16'h0014, 32'h2468ACE0, "R4");
      run(0, 0, 1, 2'd2, 5'd9, 5'd7, 32'h0000, 32'h0, 16'h0002, 32'h0, "R7");
      run(1, 0, 1, 2'd1, 5'd9, 5'd7, 32'h0000, 32'h0, 16'h0003, 32'hFFFF, "R7");
      run(0, 0, 0, 2'd2, 5'd9, 5'd7, 32'h0000, 32'h0, 16'h0000, 32'h0, "R7");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule